// File: doc/BRIEF.md
# PCIe Configuration Access Engine

This block carries out one PCIe configuration read or write at a time on behalf of software. Software loads a control word that gives the access size and direction. It then loads a target word that packs bus, device, function and byte offset, plus the write data, and sets a launch bit. The engine works out the request itself:

- the request type, from a comparison of the target bus with the root port's bus number;
- the dword-aligned address word;
- the byte-enable mask, from the access size and the low offset bits.

The engine presents the request on a valid/ready handshake toward the link side and waits for a single response beat. It then records how the access ended.

On completion the launch bit reads back 0 and an interrupt-status bit is set. A status register holds a 3-bit completion code, a non-posted flag and an error flag. For reads, the data returned by the link partner lands in a read-data register; failed reads produce fixed substitute values. A request to a non-zero device on the root bus is never sent to the link. A launch attempt made while busy is refused and noted in a sticky flag. A programmable watchdog ends an access that receives no response.

Register words, selected by `reg_addr`:

| Index | Register | Contents |
|---|---|---|
| 0 | control | bits 5:4 size, bit 6 write; type readback in bits 3:0 |
| 1 | target | bits 27:0 |
| 2 | write data | |
| 3 | read data | read-only |
| 4 | launch / busy | bit 0 |
| 5 | interrupt status | bit 0, write-1-to-clear |
| 6 | status | see R6 and R8 |
| 7 | response timeout limit | |

Top module: `pio_cfg_engine`

## Requirements
- R1: The type readback (control bits 3:0) and `req_type` are 0x8 for a read and 0xA for a write when the target bus (target bits 27:20) equals `root_bus`. They are 0x9 for a read and 0xB for a write on any other bus.
- R2: `req_addr` carries bus in bits 27:20, device in 19:15, function in 14:12 and the target offset ANDed with 0xFFC in bits 11:0. Bits 31:28 are zero.
- R3: `req_strb` is 4'b0001, 4'b0011 or 4'b1111 for size code 0, 1 or 2/3, shifted left by target bits 1:0 and truncated to 4 bits.
- R4: A launch whose target bus equals `root_bus` with a device number above 0 issues no request. It completes on the launch edge. A read sets read data to 0xFFFFFFFF; a write changes nothing but status.
- R5: Writing 1 to launch bit 0 starts an access. The launch bit reads 1 until the access ends and 0 afterwards. Completion sets interrupt-status bit 0, which is cleared by writing 1 to it.
- R6: On completion, status bits 9:7 hold the completion code (0 success, 1 unsupported request, 2 configuration retry, 4 completer abort). Bit 10 reads 1 (non-posted). Bit 11 is the response error flag, or 1 on timeout.
- R7: A read ending with code 0 and no error stores `rsp_data`. Code 2 stores 0xFFFF0001. Any other ending stores 0xFFFFFFFF. A write leaves read data unchanged.
- R8: A launch write while busy is ignored: no second request is issued. It sets sticky status bit 12, which is cleared by writing status with bit 12 set.
- R9: If no response ends the access within the timeout limit L, the access ends after L+1 busy cycles with code 4 and error flag 1, and interrupt status is set.
- R10: `req_valid` stays high with `req_type`, `req_addr`, `req_strb` and `req_wdata` stable until `req_ready` is seen, unless a timeout ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_bus | input | 8 | Bus number of the root port |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Link side accepts the request |
| req_type | output | 4 | Request type code |
| req_addr | output | 32 | Request address word |
| req_wdata | output | 32 | Request write data |
| req_strb | output | 4 | Request byte enables |
| rsp_valid | input | 1 | Response beat valid |
| rsp_status | input | 3 | Completion code from the link partner |
| rsp_err | input | 1 | Completion error flag from the link partner |
| rsp_data | input | 32 | Read data from the link partner |

## Verification
The bench aims at the paths that split on address decode:
- An inverted bus comparison would show up as wrong type codes.
- A mis-shifted or untruncated mask would show up as a wrong `req_strb` for odd offsets.
- A design that forwards a request to a non-zero device on the root bus would show up as an unexpected request seen by the link model.

The bench also probes how the access ends. It looks for wrong substitute data on retry, abort and error reads, and for read data corrupted by a failed write. It checks for a second request leaking out of a launch made while busy, and for a timeout that ends one cycle early or late or reports the wrong code.

// File: rtl/pio_cfg_pkg.sv
package pio_cfg_pkg;

    localparam int DATA_W  = 32;
    localparam int RIDX_W  = 3;
    localparam int STRB_W  = DATA_W / 8;
    localparam int TGT_W   = 28;

    // register word indices
    localparam logic [RIDX_W-1:0] IDX_CTRL   = 3'd0;
    localparam logic [RIDX_W-1:0] IDX_TARGET = 3'd1;
    localparam logic [RIDX_W-1:0] IDX_WDATA  = 3'd2;
    localparam logic [RIDX_W-1:0] IDX_RDATA  = 3'd3;
    localparam logic [RIDX_W-1:0] IDX_START  = 3'd4;
    localparam logic [RIDX_W-1:0] IDX_ISR    = 3'd5;
    localparam logic [RIDX_W-1:0] IDX_STATUS = 3'd6;
    localparam logic [RIDX_W-1:0] IDX_TMO    = 3'd7;

    // completion codes
    localparam logic [2:0] CPL_OK   = 3'd0;
    localparam logic [2:0] CPL_UR   = 3'd1;
    localparam logic [2:0] CPL_RTRY = 3'd2;
    localparam logic [2:0] CPL_ABRT = 3'd4;

    localparam logic [DATA_W-1:0] RD_ONES = '1;
    localparam logic [DATA_W-1:0] RD_RTRY = 32'hFFFF_0001;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ISSUE = 2'd1,
        XS_WAIT  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic [3:0]        typ;
        logic [DATA_W-1:0] addr;
        logic [STRB_W-1:0] strb;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    function automatic logic [3:0] pick_type(input logic is_wr, input logic local_bus);
        logic [3:0] t;
        t = is_wr ? 4'hA : 4'h8;
        return t | {3'b000, ~local_bus};
    endfunction

    function automatic logic [STRB_W-1:0] calc_strb(input logic [1:0] size, input logic [1:0] off);
        logic [STRB_W-1:0] base;
        case (size)
            2'd0:    base = 4'b0001;
            2'd1:    base = 4'b0011;
            default: base = 4'b1111;
        endcase
        return base << off;
    endfunction

endpackage

// File: rtl/pio_req_builder.sv
module pio_req_builder
    import pio_cfg_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              is_wr,
    input  logic [TGT_W-1:0]  target,
    input  logic [DATA_W-1:0] wdata,
    input  logic [7:0]        root_bus,
    output cfg_req_t          req,
    output logic              drop
);
    logic [7:0] bus;
    logic [4:0] dev;
    logic       local_bus;

    assign bus       = target[27:20];
    assign dev       = target[19:15];
    assign local_bus = (bus == root_bus);
    assign drop      = local_bus && (dev != 5'd0);

    always_comb begin
        req.typ   = pick_type(is_wr, local_bus);
        req.addr  = {4'b0000, target[27:2], 2'b00};
        req.strb  = calc_strb(size, target[1:0]);
        req.wdata = wdata;
    end
endmodule

// File: rtl/pio_xfer_fsm.sv
module pio_xfer_fsm
    import pio_cfg_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [2:0]       rsp_status,
    input  logic             rsp_err,
    output logic             busy,
    output logic             req_valid,
    output logic             done,
    output logic [2:0]       done_code,
    output logic             done_err,
    output logic             tmo_hit
);
    xfer_state_e      st;
    logic [TMO_W-1:0] cnt;
    logic             rsp_take;
    logic             req_take;

    assign busy      = (st != XS_IDLE);
    assign req_valid = (st == XS_ISSUE);
    assign rsp_take  = (st == XS_WAIT) && rsp_valid;
    assign req_take  = (st == XS_ISSUE) && req_ready;
    assign tmo_hit   = busy && (cnt >= tmo_limit) && !rsp_take && !req_take;
    assign done      = rsp_take || tmo_hit;
    assign done_code = tmo_hit ? CPL_ABRT : rsp_status;
    assign done_err  = tmo_hit || rsp_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= XS_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                XS_IDLE: begin
                    cnt <= '0;
                    if (launch) st <= XS_ISSUE;
                end
                XS_ISSUE: begin
                    cnt <= cnt + 1'b1;
                    if (tmo_hit)        st <= XS_IDLE;
                    else if (req_ready) st <= XS_WAIT;
                end
                XS_WAIT: begin
                    cnt <= cnt + 1'b1;
                    if (rsp_valid || tmo_hit) st <= XS_IDLE;
                end
                default: st <= XS_IDLE;
            endcase
        end
    end

    // R10: the request is held until it is taken or the watchdog fires
    assert_valid_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !tmo_hit) |=> req_valid);

    // R9: a timeout always returns the engine to idle
    assert_tmo_idle_R9: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> !busy);

    // R8: a launch is only accepted from idle
    assert_launch_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (launch && !busy) |=> (busy && req_valid));
endmodule

// File: rtl/pio_cfg_engine.sv
module pio_cfg_engine
    import pio_cfg_pkg::*;
#(
    parameter int                TMO_W       = 16,
    parameter logic [TMO_W-1:0]  TMO_DEFAULT = 16'd1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        root_bus,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [3:0]        req_type,
    output logic [31:0]       req_addr,
    output logic [31:0]       req_wdata,
    output logic [3:0]        req_strb,
    input  logic              rsp_valid,
    input  logic [2:0]        rsp_status,
    input  logic              rsp_err,
    input  logic [31:0]       rsp_data
);
    localparam int CODE_LSB = 7;

    logic [1:0]        ctrl_size;
    logic              ctrl_wr;
    logic [TGT_W-1:0]  target;
    logic [DATA_W-1:0] wdata_r;
    logic [DATA_W-1:0] rdata_r;
    logic              isr;
    logic [2:0]        cpl_code;
    logic              np_flag;
    logic              err_flag;
    logic              ovr_flag;
    logic [TMO_W-1:0]  tmo_lim;
    logic [3:0]        last_type;
    logic              cur_wr;
    cfg_req_t          req_r;

    cfg_req_t          built;
    logic              drop;
    logic              busy;
    logic              done;
    logic [2:0]        done_code;
    logic              done_err;
    logic              tmo_hit;

    logic              start_wr;
    logic              launch;
    logic              drop_done;

    pio_req_builder u_build (
        .size     (ctrl_size),
        .is_wr    (ctrl_wr),
        .target   (target),
        .wdata    (wdata_r),
        .root_bus (root_bus),
        .req      (built),
        .drop     (drop)
    );

    assign start_wr  = reg_we && (reg_addr == IDX_START) && reg_wdata[0];
    assign launch    = start_wr && !busy && !drop;
    assign drop_done = start_wr && !busy && drop;

    pio_xfer_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .tmo_limit  (tmo_lim),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_err    (rsp_err),
        .busy       (busy),
        .req_valid  (req_valid),
        .done       (done),
        .done_code  (done_code),
        .done_err   (done_err),
        .tmo_hit    (tmo_hit)
    );

    function automatic logic [DATA_W-1:0] read_result(input logic [2:0] code, input logic e,
                                                      input logic [DATA_W-1:0] d);
        if (code == CPL_OK && !e) return d;
        if (code == CPL_RTRY)     return RD_RTRY;
        return RD_ONES;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_size <= 2'd0;
            ctrl_wr   <= 1'b0;
            target    <= '0;
            wdata_r   <= '0;
            rdata_r   <= '0;
            isr       <= 1'b0;
            cpl_code  <= CPL_OK;
            np_flag   <= 1'b0;
            err_flag  <= 1'b0;
            ovr_flag  <= 1'b0;
            tmo_lim   <= TMO_DEFAULT;
            last_type <= 4'h0;
            cur_wr    <= 1'b0;
            req_r     <= '0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    IDX_CTRL: begin
                        ctrl_size <= reg_wdata[5:4];
                        ctrl_wr   <= reg_wdata[6];
                    end
                    IDX_TARGET: target  <= reg_wdata[TGT_W-1:0];
                    IDX_WDATA:  wdata_r <= reg_wdata;
                    IDX_TMO:    tmo_lim <= reg_wdata[TMO_W-1:0];
                    IDX_ISR:    if (reg_wdata[0]) isr <= 1'b0;
                    IDX_STATUS: if (reg_wdata[12]) ovr_flag <= 1'b0;
                    default: ;
                endcase
            end
            if (start_wr && busy) ovr_flag <= 1'b1;
            if (start_wr && !busy) begin
                last_type <= built.typ;
                cur_wr    <= ctrl_wr;
            end
            if (launch) req_r <= built;
            if (drop_done) begin
                isr      <= 1'b1;
                cpl_code <= CPL_OK;
                np_flag  <= 1'b1;
                err_flag <= 1'b0;
                if (!ctrl_wr) rdata_r <= RD_ONES;
            end
            if (done) begin
                isr      <= 1'b1;
                cpl_code <= done_code;
                np_flag  <= 1'b1;
                err_flag <= done_err;
                if (!cur_wr) rdata_r <= read_result(done_code, done_err, rsp_data);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL:   reg_rdata = {25'd0, ctrl_wr, ctrl_size, last_type};
            IDX_TARGET: reg_rdata = {4'd0, target};
            IDX_WDATA:  reg_rdata = wdata_r;
            IDX_RDATA:  reg_rdata = rdata_r;
            IDX_START:  reg_rdata = {31'd0, busy};
            IDX_ISR:    reg_rdata = {31'd0, isr};
            IDX_STATUS: reg_rdata = {19'd0, ovr_flag, err_flag, np_flag,
                                     cpl_code, {CODE_LSB{1'b0}}};
            IDX_TMO:    reg_rdata[TMO_W-1:0] = tmo_lim;
            default:    reg_rdata = '0;
        endcase
    end

    assign req_type  = req_r.typ;
    assign req_addr  = req_r.addr;
    assign req_wdata = req_r.wdata;
    assign req_strb  = req_r.strb;

    // R10: request fields do not move while waiting for acceptance
    assert_fields_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !tmo_hit) |=>
            ($stable(req_addr) && $stable(req_type) && $stable(req_strb) && $stable(req_wdata)));

    // R8: a launch attempt while busy raises the sticky flag
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (start_wr && busy) |=> ovr_flag);

    // R5: every completion leaves interrupt status set
    assert_isr_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        (done || drop_done) |=> isr);

    // R9: a watchdog ending records completer abort with error
    assert_tmo_code_R9: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> (cpl_code == CPL_ABRT && err_flag));

    // R3: an issued request never carries an empty byte mask
    assert_strb_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_strb != 4'b0000));

    // R2: the upper nibble of the address word is always zero
    assert_addr_top_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[31:28] == 4'b0000));
endmodule

// File: tb/test_pio_cfg_engine.sv
`timescale 1ns/1ps
module test_pio_cfg_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  root_bus = 8'h02;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [3:0]  req_type;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_status = 3'd0;
    logic        rsp_err = 1'b0;
    logic [31:0] rsp_data = '0;

    always #2 clk = ~clk;

    pio_cfg_engine i_pio_cfg_engine (
        .clk(clk), .rst(rst), .root_bus(root_bus),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    typedef struct {
        logic [3:0]  typ;
        logic [31:0] addr;
        logic [3:0]  strb;
        logic [31:0] wdata;
        bit          is_wr;
    } exp_req_t;
    exp_req_t exp_q[$];

    // link partner model settings
    int          m_rdy_dly = 0;
    int          m_rsp_dly = 0;
    logic [2:0]  m_status = 3'd0;
    logic        m_err = 1'b0;
    logic [31:0] m_data = '0;
    bit          m_no_rsp = 0;
    int          ph = 0;
    int          mcnt = 0;
    int          seen = 0;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // link model and request monitor (scoreboard pop side)
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        req_ready = 1'b0;
        if (rst) begin
            ph = 0; mcnt = 0;
        end else if (ph == 0 && req_valid && !m_no_rsp) begin
            if (mcnt >= m_rdy_dly) begin
                req_ready = 1'b1;
                ph = 1; mcnt = 0;
                seen++;
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected request", {28'd0, req_type}, 32'hFFFF_FFFF);
                end else begin
                    exp_req_t e;
                    e = exp_q.pop_front();
                    chk("R1 type", {28'd0, req_type}, {28'd0, e.typ});
                    chk("R2 addr", req_addr, e.addr);
                    chk("R3 strb", {28'd0, req_strb}, {28'd0, e.strb});
                    if (e.is_wr) chk("R10 wdata", req_wdata, e.wdata);
                end
            end else mcnt++;
        end else if (ph == 1) begin
            if (mcnt >= m_rsp_dly) begin
                rsp_valid  = 1'b1;
                rsp_status = m_status;
                rsp_err    = m_err;
                rsp_data   = m_data;
                ph = 0; mcnt = 0;
            end else mcnt++;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: program, push expectation, launch, wait
    task automatic do_xfer(input logic [31:0] ctrl, input logic [31:0] tgt, input logic [31:0] wd,
                           input logic [3:0] et, input logic [31:0] ea, input logic [3:0] es,
                           input bit issue);
        logic [31:0] v;
        exp_req_t e;
        reg_write(3'd5, 32'h1);
        reg_write(3'd0, ctrl);
        reg_write(3'd1, tgt);
        reg_write(3'd2, wd);
        if (issue) begin
            e.typ = et; e.addr = ea; e.strb = es; e.wdata = wd; e.is_wr = ctrl[6];
            exp_q.push_back(e);
        end
        reg_write(3'd4, 32'h1);
        for (int i = 0; i < 300; i++) begin
            reg_read(3'd4, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        int seen0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        reg_read(3'd6, v); chk("R6 reset status", v, 32'h0);
        reg_read(3'd5, v); chk("R5 reset isr", v, 32'h0);
        reg_read(3'd4, v); chk("R5 reset start", v, 32'h0);
        reg_read(3'd3, v); chk("R7 reset rdata", v, 32'h0);
        chk("R10 reset valid", {31'd0, req_valid}, 32'h0);

        // R1 R2 R3 R7: type 0 read, dword, success
        m_rdy_dly = 2; m_rsp_dly = 1; m_status = 3'd0; m_err = 0; m_data = 32'h1234_5678;
        do_xfer(32'h20, 32'h0020_2010, 32'h0, 4'h8, 32'h0020_2010, 4'hF, 1);
        reg_read(3'd3, v); chk("R7 read data", v, 32'h1234_5678);
        reg_read(3'd6, v); chk("R6 status ok np", v, 32'h0000_0400);
        reg_read(3'd5, v); chk("R5 isr set", v, 32'h1);
        reg_read(3'd0, v); chk("R1 ctrl type rd0", {28'd0, v[3:0]}, 32'h8);
        reg_write(3'd5, 32'h1);
        reg_read(3'd5, v); chk("R5 isr w1c", v, 32'h0);

        // R1 R3: type 1 write, byte at offset 3
        m_rdy_dly = 0;
        do_xfer(32'h40, 32'h0051_9043, 32'hAB00_0000, 4'hB, 32'h0051_9040, 4'h8, 1);
        reg_read(3'd3, v); chk("R7 write keeps rdata", v, 32'h1234_5678);

        // R1 R3: type 0 write, half at offset 2
        do_xfer(32'h50, 32'h0020_0006, 32'hBEEF_0000, 4'hA, 32'h0020_0004, 4'hC, 1);
        // R3: dword at offset 1 truncates to 4'b1110
        do_xfer(32'h60, 32'h0030_0001, 32'h1, 4'hB, 32'h0030_0000, 4'hE, 1);

        // R6 R7: type 1 read, unsupported request
        m_status = 3'd1;
        do_xfer(32'h20, 32'h0070_8000, 32'h0, 4'h9, 32'h0070_8000, 4'hF, 1);
        reg_read(3'd3, v); chk("R7 UR data", v, 32'hFFFF_FFFF);
        reg_read(3'd6, v); chk("R6 UR code", {29'd0, v[9:7]}, 32'h1);

        // R7: configuration retry read
        m_status = 3'd2;
        do_xfer(32'h20, 32'h0020_0000, 32'h0, 4'h8, 32'h0020_0000, 4'hF, 1);
        reg_read(3'd3, v); chk("R7 retry data", v, 32'hFFFF_0001);
        reg_read(3'd6, v); chk("R6 retry code", {29'd0, v[9:7]}, 32'h2);

        // R6 R7: completion error on success code
        m_status = 3'd0; m_err = 1;
        do_xfer(32'h20, 32'h0020_0000, 32'h0, 4'h8, 32'h0020_0000, 4'hF, 1);
        reg_read(3'd3, v); chk("R7 error data", v, 32'hFFFF_FFFF);
        reg_read(3'd6, v); chk("R6 error flag", v, 32'h0000_0C00);

        // R7: completer abort read
        m_err = 0; m_status = 3'd4;
        do_xfer(32'h20, 32'h0090_0000, 32'h0, 4'h9, 32'h0090_0000, 4'hF, 1);
        reg_read(3'd6, v); chk("R6 abort code", v, 32'h0000_0600);

        // R7: good read then failing write keeps data
        m_status = 3'd0; m_data = 32'hA5A5_0F0F;
        do_xfer(32'h10, 32'h0020_0005, 32'h0, 4'h8, 32'h0020_0004, 4'h6, 1);
        reg_read(3'd3, v); chk("R7 half read data", v, 32'hA5A5_0F0F);
        m_status = 3'd1;
        do_xfer(32'h60, 32'h0088_0000, 32'h5, 4'hB, 32'h0088_0000, 4'hF, 1);
        reg_read(3'd3, v); chk("R7 failed write keeps rdata", v, 32'hA5A5_0F0F);
        reg_read(3'd6, v); chk("R6 write UR", v, 32'h0000_0480);

        // R4: dropped read and write on root bus with device above 0
        seen0 = seen;
        do_xfer(32'h20, 32'h0021_8000, 32'h0, 4'h0, 32'h0, 4'h0, 0);
        reg_read(3'd3, v); chk("R4 drop read ones", v, 32'hFFFF_FFFF);
        reg_read(3'd5, v); chk("R4 drop isr", v, 32'h1);
        reg_read(3'd6, v); chk("R4 drop status", v, 32'h0000_0400);
        m_data = 32'h0;
        do_xfer(32'h60, 32'h0020_8004, 32'h7, 4'h0, 32'h0, 4'h0, 0);
        repeat (4) @(negedge clk);
        chk("R4 no request issued", seen - seen0, 0);

        // R8: launch while busy ignored, sticky flag, w1c
        m_status = 3'd0; m_rdy_dly = 8; m_data = 32'h0BAD_F00D;
        seen0 = seen;
        reg_write(3'd5, 32'h1);
        reg_write(3'd0, 32'h20);
        reg_write(3'd1, 32'h0030_0000);
        exp_q.push_back('{4'h9, 32'h0030_0000, 4'hF, 32'h0, 1'b0});
        reg_write(3'd4, 32'h1);
        reg_write(3'd4, 32'h1);
        reg_read(3'd6, v); chk("R8 overrun set", {31'd0, v[12]}, 32'h1);
        for (int i = 0; i < 100; i++) begin
            reg_read(3'd4, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
        chk("R8 single request", seen - seen0, 1);
        reg_read(3'd3, v); chk("R8 data of first request", v, 32'h0BAD_F00D);
        reg_read(3'd6, v); chk("R8 overrun sticky", {31'd0, v[12]}, 32'h1);
        reg_write(3'd6, 32'h0000_1000);
        reg_read(3'd6, v); chk("R8 overrun cleared", {31'd0, v[12]}, 32'h0);

        // R9: timeout after limit+1 busy cycles
        m_no_rsp = 1; m_rdy_dly = 0;
        reg_write(3'd7, 32'd5);
        reg_write(3'd5, 32'h1);
        reg_write(3'd0, 32'h20);
        reg_write(3'd1, 32'h0040_0000);
        reg_write(3'd4, 32'h1);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            reg_read(3'd4, v);
            if (v[0] == 1'b0) break;
            n++;
            @(negedge clk);
        end
        chk("R9 busy cycles", n, 6);
        reg_read(3'd6, v); chk("R9 timeout status", v, 32'h0000_0E00);
        reg_read(3'd5, v); chk("R9 timeout isr", v, 32'h1);
        reg_read(3'd3, v); chk("R9 timeout rdata", v, 32'hFFFF_FFFF);
        chk("R9 queue empty", exp_q.size(), 0);

        finish_run();
    end
endmodule